// File: doc/BRIEF.md
# Latched Wide-Entry Address Table Port

This block fronts a MAC address lookup memory whose entries are 64 bits wide. A host can only move 32 bits at a time, so it reaches each entry as two words: first the lower word, then the upper one. Holding latches make every entry transfer atomic. A lower-word write only stages data, and the whole entry is stored when the upper word arrives. A lower-word read copies the whole entry into a snapshot, and the upper-word read returns the top half of that same copy. The table therefore never holds, and the host never sees, a mix of two versions of one entry.

A second write path serves a hardware learning engine. Its updates always store dynamic entries. They are refused for any entry that the host last stored as static, where bit 49 of the entry is the record-type flag (1 means static). The table is single-ported and the host always has priority for it. A learning write is carried out only in a cycle where the host is not using the table, and a one-cycle acknowledge confirms that it was stored. The table index is formed from a hash block number in the upper index bits and an entry slot within the block in the lower bits. By default there are 256 blocks of 8 slots each.

Top module: `wide_entry_port`

## Requirements
- R1: After reset, `host_rvalid`, `lrn_ack` and `seq_err` are 0 and `host_rdata` is 0.
- R2: A lower-word write (`host_write`=1, `host_hi`=0) stages the word and the index and leaves the stored entry unchanged.
- R3: An upper-word write (`host_hi`=1) that follows a staged lower word stores {upper word, staged lower word} at the staged index in one step. The `host_index` value given with the upper word is ignored.
- R4: A lower-word read captures all 64 bits of the entry. The next upper-word read returns bits 63:32 of that capture, even if the entry was changed in between.
- R5: Read data appears on `host_rdata`, with `host_rvalid` high for one cycle, two rising edges after the read is presented. `host_rvalid` is 0 one edge after it.
- R6: An upper-word write with no staged lower word, or an upper-word read with no preceding lower-word read, is ignored. It sets `seq_err`, which stays 1 until reset.
- R7: A lower-word access replaces any sequence in progress. A new lower-word write replaces the staged word and index. A lower-word read abandons a staged write, and a lower-word write abandons an armed read.
- R8: A learning write is stored with bit 49 forced to 0 when the target entry is not static and the host is not using the table that cycle. `lrn_ack` is 1 one edge later.
- R9: A learning write to an entry whose last host-stored bit 49 was 1 is dropped and gives no `lrn_ack`.
- R10: A learning write in the same cycle as a host commit or a lower-word read is dropped and gives no `lrn_ack`. This holds even when both target the same entry, and the host value is kept.
- R11: The static marking of an entry follows its most recent host commit, so storing bit 49 as 0 opens the entry to learning again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host access this cycle |
| host_write | input | 1 | 1 write, 0 read |
| host_hi | input | 1 | 1 upper word, 0 lower word |
| host_index | input | 11 | Entry index {hash block, slot}, used by lower-word accesses |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | Host read word |
| host_rvalid | output | 1 | Read word valid pulse |
| seq_err | output | 1 | Sticky access-order error |
| lrn_valid | input | 1 | Learning write request |
| lrn_index | input | 11 | Learning target index |
| lrn_entry | input | 64 | Learning entry value |
| lrn_ack | output | 1 | Learning write was stored |

## Verification
`lrn_ack` and `seq_err` follow a stimulus by one rising edge. Read words and `host_rvalid` follow it by two. The bench presents each access for exactly one cycle and leaves a following idle cycle. It samples on the falling edge after the first edge, where it checks the acknowledge and expects `host_rvalid` low, and again after the second edge, where it checks read data and the error flag. A reference model advances once per access, so each expected value belongs to exactly one sampled cycle.

// File: rtl/wep_pkg.sv
package wep_pkg;

    localparam int WORD_W   = 32;
    localparam int ENTRY_W  = 2 * WORD_W;
    localparam int TYPE_BIT = 49;

    typedef enum logic [1:0] {
        ARM_NONE  = 2'd0,
        ARM_WRITE = 2'd1,
        ARM_READ  = 2'd2
    } arm_e;

    typedef struct packed {
        logic lo_wr;
        logic hi_wr;
        logic lo_rd;
        logic hi_rd;
    } host_op_t;

    function automatic host_op_t decode_op(input logic v, input logic w, input logic hi);
        host_op_t o;
        o.lo_wr = v &  w & ~hi;
        o.hi_wr = v &  w &  hi;
        o.lo_rd = v & ~w & ~hi;
        o.hi_rd = v & ~w &  hi;
        return o;
    endfunction

    function automatic logic [ENTRY_W-1:0] as_dynamic(input logic [ENTRY_W-1:0] e);
        logic [ENTRY_W-1:0] r;
        r = e;
        r[TYPE_BIT] = 1'b0;
        return r;
    endfunction

    function automatic logic is_static(input logic [ENTRY_W-1:0] e);
        return e[TYPE_BIT];
    endfunction

endpackage

// File: rtl/wep_entry_ram.sv
module wep_entry_ram #(
    parameter int DEPTH = 2048,
    parameter int W     = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    // Output register only updates on a read, so it doubles as the snapshot.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                rdata <= mem[addr];
            end
        end
    end

endmodule

// File: rtl/wep_static_map.sv
module wep_static_map #(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_we,
    input  logic [AW-1:0] set_idx,
    input  logic          set_val,
    input  logic [AW-1:0] q_idx,
    output logic          q_static
);

    logic [DEPTH-1:0] flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else if (set_we) begin
            flags[set_idx] <= set_val;
        end
    end

    assign q_static = flags[q_idx];

    AST_STATIC_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        set_we |=> (flags[$past(set_idx)] == $past(set_val))) else $error("static flag not updated"); // R11

endmodule

// File: rtl/wep_host_seq.sv
module wep_host_seq
    import wep_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  host_op_t           op,
    input  logic [IDX_W-1:0]   host_index,
    input  logic [WORD_W-1:0]  host_wdata,
    input  logic [ENTRY_W-1:0] snap,
    output logic               port_rd,
    output logic               port_commit,
    output logic [IDX_W-1:0]   port_idx,
    output logic [ENTRY_W-1:0] port_wdata,
    output logic [WORD_W-1:0]  host_rdata,
    output logic               host_rvalid,
    output logic               seq_err
);

    arm_e              arm_q;
    logic [IDX_W-1:0]  lat_idx;
    logic [WORD_W-1:0] lat_lo;
    logic              hi_rd_ok;
    logic              bad;
    logic              hi_any;
    logic              st_v;
    logic              st_hi;

    always_comb begin
        port_commit = op.hi_wr && (arm_q == ARM_WRITE);
        hi_rd_ok    = op.hi_rd && (arm_q == ARM_READ);
        bad         = (op.hi_wr && (arm_q != ARM_WRITE)) ||
                      (op.hi_rd && (arm_q != ARM_READ));
        hi_any      = op.hi_wr | op.hi_rd;
        port_rd     = op.lo_rd;
        port_idx    = op.lo_rd ? host_index : lat_idx;
        port_wdata  = {host_wdata, lat_lo};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q       <= ARM_NONE;
            lat_idx     <= '0;
            lat_lo      <= '0;
            seq_err     <= 1'b0;
            st_v        <= 1'b0;
            st_hi       <= 1'b0;
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            if (op.lo_wr) begin
                arm_q   <= ARM_WRITE;
                lat_idx <= host_index;
                lat_lo  <= host_wdata;
            end else if (op.lo_rd) begin
                arm_q <= ARM_READ;
            end else if (port_commit || hi_rd_ok) begin
                arm_q <= ARM_NONE;
            end
            if (bad) begin
                seq_err <= 1'b1;
            end
            st_v        <= op.lo_rd | hi_rd_ok;
            st_hi       <= hi_rd_ok;
            host_rvalid <= st_v;
            if (st_v) begin
                host_rdata <= st_hi ? snap[ENTRY_W-1:WORD_W] : snap[WORD_W-1:0];
            end
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> seq_err) else $error("seq_err cleared"); // R6
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_err) |-> $past(hi_any)) else $error("seq_err without upper access"); // R6
    AST_RVALID_SRC: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |-> $past(port_rd | hi_rd_ok, 2)) else $error("rvalid without read"); // R5

endmodule

// File: rtl/wide_entry_port.sv
module wide_entry_port
    import wep_pkg::*;
#(
    parameter int BLOCKS  = 256,
    parameter int WAYS    = 8,
    localparam int DEPTH  = BLOCKS * WAYS,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_valid,
    input  logic               host_write,
    input  logic               host_hi,
    input  logic [IDX_W-1:0]   host_index,
    input  logic [WORD_W-1:0]  host_wdata,
    output logic [WORD_W-1:0]  host_rdata,
    output logic               host_rvalid,
    output logic               seq_err,
    input  logic               lrn_valid,
    input  logic [IDX_W-1:0]   lrn_index,
    input  logic [ENTRY_W-1:0] lrn_entry,
    output logic               lrn_ack
);

    host_op_t           op;
    logic               port_rd;
    logic               port_commit;
    logic [IDX_W-1:0]   port_idx;
    logic [ENTRY_W-1:0] port_wdata;
    logic [ENTRY_W-1:0] snap;
    logic               lrn_static;
    logic               host_busy;
    logic               lrn_we;
    logic               ram_en;
    logic               ram_we;
    logic [IDX_W-1:0]   ram_addr;
    logic [ENTRY_W-1:0] ram_wdata;

    assign op = decode_op(host_valid, host_write, host_hi);

    wep_host_seq #(.IDX_W(IDX_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .op          (op),
        .host_index  (host_index),
        .host_wdata  (host_wdata),
        .snap        (snap),
        .port_rd     (port_rd),
        .port_commit (port_commit),
        .port_idx    (port_idx),
        .port_wdata  (port_wdata),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid),
        .seq_err     (seq_err)
    );

    wep_static_map #(.DEPTH(DEPTH)) u_static (
        .clk      (clk),
        .rst      (rst),
        .set_we   (port_commit),
        .set_idx  (port_idx),
        .set_val  (is_static(port_wdata)),
        .q_idx    (lrn_index),
        .q_static (lrn_static)
    );

    // Host owns the single port whenever it uses it; learning fills idle cycles.
    always_comb begin
        host_busy = port_rd | port_commit;
        lrn_we    = lrn_valid && !host_busy && !lrn_static;
        ram_en    = host_busy | lrn_we;
        ram_we    = port_commit | lrn_we;
        ram_addr  = host_busy ? port_idx : lrn_index;
        ram_wdata = port_commit ? port_wdata : as_dynamic(lrn_entry);
    end

    wep_entry_ram #(.DEPTH(DEPTH), .W(ENTRY_W)) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (snap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lrn_ack <= 1'b0;
        end else begin
            lrn_ack <= lrn_we;
        end
    end

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
        !(port_commit && lrn_we)) else $error("two writers"); // R10
    AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (rst)
        lrn_ack |-> $past(lrn_valid && !port_rd && !port_commit)) else $error("ack while host busy"); // R10
    AST_ACK_NOT_STATIC: assert property (@(posedge clk) disable iff (rst)
        lrn_ack |-> !$past(lrn_static)) else $error("static entry learned"); // R9
    AST_LRN_DYNAMIC: assert property (@(posedge clk) disable iff (rst)
        (ram_we && !port_commit) |-> !ram_wdata[TYPE_BIT]) else $error("learned static bit"); // R8

endmodule

// File: tb/wide_entry_port_bench.sv
`timescale 1ns/1ps
module wide_entry_port_bench;

    localparam int DEPTH = 2048;
    localparam int IW    = 11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_valid = 1'b0, host_write = 1'b0, host_hi = 1'b0;
    logic [IW-1:0] host_index = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_rvalid, seq_err;
    logic        lrn_valid = 1'b0;
    logic [IW-1:0] lrn_index = '0;
    logic [63:0] lrn_entry = '0;
    logic        lrn_ack;

    int total = 0, fails = 0;
    bit done = 0;

    logic [63:0] mmem [DEPTH];
    bit          mstat [DEPTH];
    int          mseq = 0;
    int          mlat_idx = 0;
    logic [31:0] mlat_lo = '0;
    logic [63:0] msnap = '0;
    bit          merr = 0;

    always #4 clk = ~clk;

    wide_entry_port u_wide_entry_port (
        .clk(clk), .rst(rst),
        .host_valid(host_valid), .host_write(host_write), .host_hi(host_hi),
        .host_index(host_index), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .seq_err(seq_err),
        .lrn_valid(lrn_valid), .lrn_index(lrn_index), .lrn_entry(lrn_entry),
        .lrn_ack(lrn_ack)
    );

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int pool(int k);
        return (k < 8) ? k : DEPTH - 16 + k;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        host_valid = 1'b0; lrn_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mseq = 0; merr = 0;
        for (int i = 0; i < DEPTH; i++) mstat[i] = 0;
        chk("R1", "rvalid", host_rvalid, 0);
        chk("R1", "rdata", host_rdata, 0);
        chk("R1", "ack", lrn_ack, 0);
        chk("R1", "seq_err", seq_err, 0);
    endtask

    // kind: 0 idle, 1 lower write, 2 upper write, 3 lower read, 4 upper read
    task automatic op(int kind, int idx, logic [31:0] d, bit lv, int li, logic [63:0] ld, string tag);
        bit commit, rdok, bad, busy, exp_ack, exp_rv;
        logic [31:0] exp_rd;
        string atag;
        commit  = (kind == 2) && (mseq == 1);
        rdok    = (kind == 4) && (mseq == 2);
        bad     = ((kind == 2) && (mseq != 1)) || ((kind == 4) && (mseq != 2));
        busy    = (kind == 3) || commit;
        exp_ack = lv && !busy && !mstat[li];
        exp_rv  = (kind == 3) || rdok;
        atag    = busy ? "R10" : (mstat[li] ? "R9" : "R8");
        host_valid = (kind != 0);
        host_write = (kind == 1) || (kind == 2);
        host_hi    = (kind == 2) || (kind == 4);
        host_index = IW'(idx);
        host_wdata = d;
        lrn_valid  = lv;
        lrn_index  = IW'(li);
        lrn_entry  = ld;
        if (kind == 3) msnap = mmem[idx];
        if (commit) begin
            mmem[mlat_idx]  = {d, mlat_lo};
            mstat[mlat_idx] = d[17];
        end
        if (exp_ack) mmem[li] = ld & ~(64'h1 << 49);
        exp_rd = (kind == 4) ? msnap[63:32] : msnap[31:0];
        if (kind == 1) begin
            mseq = 1; mlat_idx = idx; mlat_lo = d;
        end else if (kind == 3) begin
            mseq = 2;
        end else if (commit || rdok) begin
            mseq = 0;
        end
        if (bad) merr = 1;
        @(posedge clk);
        @(negedge clk);
        host_valid = 1'b0;
        lrn_valid  = 1'b0;
        chk(lv ? atag : "R8", "lrn_ack", lrn_ack, exp_ack);
        chk("R5", "early rvalid", host_rvalid, 0);
        @(posedge clk);
        @(negedge clk);
        chk("R5", "rvalid", host_rvalid, exp_rv);
        if (exp_rv) chk(tag, "rdata", host_rdata, exp_rd);
        chk(tag, "seq_err R6", seq_err, merr);
    endtask

    task automatic wr(int idx, logic [63:0] e, string tag);
        op(1, idx, e[31:0], 0, 0, 0, tag);
        op(2, idx, e[63:32], 0, 0, 0, tag);
    endtask

    task automatic rd(int idx, string tag);
        op(3, idx, 0, 0, 0, 0, tag);
        op(4, idx, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        do_reset();
        for (int k = 0; k < 16; k++)
            wr(pool(k), {$urandom() & ~32'h20000, $urandom()}, "R3");
        for (int k = 0; k < 16; k++) rd(pool(k), "R3");

        // R3: upper-word index ignored
        op(1, 3, 32'hA1A1_0003, 0, 0, 0, "R3");
        op(2, 9, 32'h0101_0003, 0, 0, 0, "R3");
        rd(3, "R3");
        rd(9, "R3");
        // R2 and R7: staged word not stored, lower read abandons the write
        op(1, 4, 32'hDEAD_0004, 0, 0, 0, "R2");
        op(3, 4, 0, 0, 0, 0, "R2");
        op(2, 4, 32'h1234_0000, 0, 0, 0, "R7");
        chk("R7", "seq_err after abandoned write", seq_err, 1);
        do_reset();
        // R7: replacement of staged lower word
        op(1, 5, 32'h5555_0005, 0, 0, 0, "R7");
        op(1, 6, 32'h6666_0006, 0, 0, 0, "R7");
        op(2, 0, 32'h0606_0006, 0, 0, 0, "R7");
        rd(5, "R7");
        rd(6, "R7");
        // R4: snapshot survives a learning write between halves
        op(3, 7, 0, 0, 0, 0, "R4");
        op(0, 0, 0, 1, 7, 64'h7777_7777_0000_0007, "R4");
        op(4, 7, 0, 0, 0, 0, "R4");
        // R8: learned entry lands with bit 49 cleared
        op(0, 0, 0, 1, 2, 64'hFFFF_FFFF_0000_0002, "R8");
        rd(2, "R8");
        // R9: static entry refuses learning
        wr(1, 64'h0002_0000_1111_0001, "R9");
        op(0, 0, 0, 1, 1, 64'h0, "R9");
        rd(1, "R9");
        // R11: cleared record type reopens learning
        wr(1, 64'h0000_0001_2222_0001, "R11");
        op(0, 0, 0, 1, 1, 64'h0000_00AB_0000_00CD, "R11");
        rd(1, "R11");
        // R10: same-cycle commit to same entry, and a lower read elsewhere
        op(1, 0, 32'hC0C0_0000, 0, 0, 0, "R10");
        op(2, 0, 32'h0000_C0C0, 1, 0, 64'h1, "R10");
        op(3, 6, 0, 1, 0, 64'h2, "R10");
        rd(0, "R10");
        // R6: orphan upper accesses, error stays set
        do_reset();
        op(4, 0, 0, 0, 0, 0, "R6");
        op(2, 0, 32'h9, 0, 0, 0, "R6");
        rd(3, "R6");
        do_reset();

        for (int b = 0; b < 30; b++) begin
            for (int i = 0; i < 30; i++) begin
                int kind = $urandom_range(0, 4);
                logic [31:0] d = $urandom();
                if ((kind == 2) && ($urandom_range(0, 3) != 0)) d[17] = 1'b0;
                op(kind, pool($urandom_range(0, 15)), d,
                   bit'($urandom_range(0, 1)), pool($urandom_range(0, 15)),
                   {$urandom(), $urandom()}, "R4");
            end
            do_reset();
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule